// File: doc/BRIEF.md
# Exclusive RGB Channel Sequencer

The sequencer accepts three asynchronous colour requests (red, green, blue) and enables at most one LED current channel at any time. Each request passes through a two-flop synchronizer. When the sequencer is idle and several synchronized requests are high, the winner is chosen by fixed priority: green first, then blue, then red. A channel that has already been granted keeps the grant until its own request drops, even if a request with higher priority arrives in the meantime.

Before the winning channel's current is switched on, the sequencer holds a blanking interval. During this interval the channel is already selected, so the output rail can settle for that colour. The interval length comes from a per-colour delay code and is counted in one-microsecond tick pulses.

Current codes and delay codes arrive as shadow values. The sequencer copies a channel's shadow values into its applied copy only when that channel's synchronized request falls. The channel-select code and the active current code are meant for a downstream converter and current regulator.

Top module: `rgb_seq_top`

## Requirements
- R1: At most one bit of `ch_en` is high in any cycle. Bit 0 enables green, bit 1 enables blue and bit 2 enables red.
- R2: When the sequencer is idle and several synchronized requests are high, green wins over blue and blue wins over red. `ch_sel` encodes the selection as 0 = none, 1 = green, 2 = blue, 3 = red.
- R3: While a channel is enabled, `ch_en` never moves to another channel. The grant ends only when the enabled channel's own request drops.
- R4: After a channel is selected, `ch_en` stays low until 5 + 10·d tick pulses have been counted, where d is that channel's applied 2-bit delay code. `ch_en` rises on the clock edge that registers the final tick.
- R5: After reset, every channel's applied delay code is 3 (35 ticks) and every applied current code is 10'h3FF.
- R6: Shadow current and delay codes for a channel are copied to the applied copy only on the falling edge of that channel's synchronized request. Shadow changes at any other time have no effect, and `cur_code` is stable while a channel stays enabled.
- R7: `cur_code` equals the applied current code of the selected channel while `ch_sel` is nonzero, and is 0 when idle.
- R8: If the selected request drops during blanking, the sequencer returns to idle and that channel is never enabled.
- R9: When the enabled request drops, the sequencer is idle for one cycle. On the next clock it arbitrates any pending requests by priority.
- R10: A change on a raw request input first affects `ch_sel` after the third rising clock edge (two synchronizer flops plus the state register).
- R11: In reset and right after it, `ch_en`, `ch_sel` and `cur_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| req_g | input | 1 | Asynchronous green request |
| req_b | input | 1 | Asynchronous blue request |
| req_r | input | 1 | Asynchronous red request |
| shd_cur_g | input | 10 | Shadow current code, green |
| shd_cur_b | input | 10 | Shadow current code, blue |
| shd_cur_r | input | 10 | Shadow current code, red |
| shd_dly_g | input | 2 | Shadow delay code, green |
| shd_dly_b | input | 2 | Shadow delay code, blue |
| shd_dly_r | input | 2 | Shadow delay code, red |
| ch_en | output | 3 | One-hot channel enable (bit 0 = green, bit 1 = blue, bit 2 = red) |
| ch_sel | output | 2 | Selected channel (0 none, 1 green, 2 blue, 3 red) |
| cur_code | output | 10 | Current code of the selected channel |

## Verification
The following properties are checked on every cycle:
- the enable is never more than one-hot;
- a grant never jumps directly to another channel;
- an enable only follows blanking of the same channel, and the blanking tick count stays between 5 and 35;
- the current code stays stable while a channel remains enabled;
- idle means zero outputs.

Other behaviours can only be shown by the bench's scenarios:
- the priority order among simultaneous requests;
- the exact blanking length for a given delay code;
- the timing of the shadow copy at falling edges;
- abort during blanking and re-arbitration after a release;
- the synchronizer latency.

// File: rtl/rgb_seq_pkg.sv
// Shared types and encodings for the exclusive RGB sequencer.
// Channel index order is the priority order: 0 = green, 1 = blue, 2 = red.
package rgb_seq_pkg;
    localparam int NUM_CH = 3;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_BLANK = 2'd1,
        ARB_ON    = 2'd2
    } arb_state_t;
endpackage

// File: rtl/rgb_req_sync.sv
// Two-flop synchronizer plus falling-edge detector for each request line.
// Assumes the raw requests are level signals, wider than one clock period.
module rgb_req_sync #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] raw_req,
    output logic [NCH-1:0] req_lvl,
    output logic [NCH-1:0] req_fall
);
    logic [NCH-1:0] meta_q, sync_q, prev_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Synchronize one line and keep the previous synchronized value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= raw_req[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end
        assign req_fall[i] = prev_q[i] & ~sync_q[i];
    end

    assign req_lvl = sync_q;
endmodule

// File: rtl/rgb_code_bank.sv
// Applied current and delay codes for each channel, loaded from the shadow
// values only at that channel's synchronized falling edge.
// Reset defaults: current all-ones, delay code all-ones.
module rgb_code_bank #(
    parameter int NCH   = 3,
    parameter int CUR_W = 10,
    parameter int DLY_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       load,
    input  logic [NCH*CUR_W-1:0] shd_cur,
    input  logic [NCH*DLY_W-1:0] shd_dly,
    output logic [NCH*CUR_W-1:0] app_cur,
    output logic [NCH*DLY_W-1:0] app_dly
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Copy shadow to applied on this channel's falling edge only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                app_cur[i*CUR_W +: CUR_W] <= '1;
                app_dly[i*DLY_W +: DLY_W] <= '1;
            end else if (load[i]) begin
                app_cur[i*CUR_W +: CUR_W] <= shd_cur[i*CUR_W +: CUR_W];
                app_dly[i*DLY_W +: DLY_W] <= shd_dly[i*DLY_W +: DLY_W];
            end
        end
    end
endmodule

// File: rtl/rgb_arbiter.sv
// Fixed-priority, non-pre-emptive grant FSM with per-channel blanking.
// Lowest index wins among simultaneous requests seen in idle. The blanking
// length is MIN_US + STEP_US * code ticks of tick_us.
// Assumes MIN_US >= 1 and synchronized request levels.
module rgb_arbiter
    import rgb_seq_pkg::*;
#(
    parameter int NCH     = 3,
    parameter int DLY_W   = 2,
    parameter int MIN_US  = 5,
    parameter int STEP_US = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_us,
    input  logic [NCH-1:0]       req_lvl,
    input  logic [NCH*DLY_W-1:0] app_dly,
    output logic                 sel_vld,
    output logic                 on_vld,
    output logic [$clog2(NCH)-1:0] sel_idx
);
    localparam int MAX_US = MIN_US + STEP_US * ((1 << DLY_W) - 1);
    localparam int CNT_W  = $clog2(MAX_US + 1);
    localparam int IDX_W  = $clog2(NCH);

    arb_state_t       state_q;
    logic [IDX_W-1:0] idx_q, win_idx;
    logic [CNT_W-1:0] cnt_q, tgt_q, win_tgt;
    logic [DLY_W-1:0] win_code;

    // Pick the lowest-index pending request.
    always_comb begin
        win_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req_lvl[i]) win_idx = IDX_W'(i);
        end
    end

    // Blanking length for the winner, taken from its applied delay code.
    always_comb begin
        win_code = app_dly[win_idx*DLY_W +: DLY_W];
        win_tgt  = CNT_W'(MIN_US) + CNT_W'(STEP_US) * CNT_W'(win_code);
    end

    // Grant state machine: idle -> blank -> on, with abort and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            tgt_q   <= '0;
        end else begin
            case (state_q)
                ARB_IDLE: begin
                    if (|req_lvl) begin
                        state_q <= ARB_BLANK;
                        idx_q   <= win_idx;
                        tgt_q   <= win_tgt;
                        cnt_q   <= '0;
                    end
                end
                ARB_BLANK: begin
                    if (!req_lvl[idx_q]) begin
                        state_q <= ARB_IDLE;
                    end else if (tick_us) begin
                        if (cnt_q + CNT_W'(1) == tgt_q) begin
                            state_q <= ARB_ON;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                ARB_ON: begin
                    if (!req_lvl[idx_q]) state_q <= ARB_IDLE;
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    assign sel_vld = (state_q != ARB_IDLE);
    assign on_vld  = (state_q == ARB_ON);
    assign sel_idx = idx_q;
endmodule

// File: rtl/rgb_seq_top.sv
// Exclusive RGB sequencer top: synchronizes the colour requests, holds the
// applied codes, grants one channel at a time and drives the enable,
// select code and current code. Internal order: 0 green, 1 blue, 2 red.
module rgb_seq_top #(
    parameter int CUR_W   = 10,
    parameter int DLY_W   = 2,
    parameter int MIN_US  = 5,
    parameter int STEP_US = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_us,
    input  logic             req_g,
    input  logic             req_b,
    input  logic             req_r,
    input  logic [CUR_W-1:0] shd_cur_g,
    input  logic [CUR_W-1:0] shd_cur_b,
    input  logic [CUR_W-1:0] shd_cur_r,
    input  logic [DLY_W-1:0] shd_dly_g,
    input  logic [DLY_W-1:0] shd_dly_b,
    input  logic [DLY_W-1:0] shd_dly_r,
    output logic [2:0]       ch_en,
    output logic [1:0]       ch_sel,
    output logic [CUR_W-1:0] cur_code
);
    import rgb_seq_pkg::*;
    localparam int IDX_W = $clog2(NUM_CH);

    logic [NUM_CH-1:0]       lvl, fall;
    logic [NUM_CH*CUR_W-1:0] app_cur;
    logic [NUM_CH*DLY_W-1:0] app_dly;
    logic                    sel_vld, on_vld;
    logic [IDX_W-1:0]        sel_idx;

    rgb_req_sync #(.NCH(NUM_CH)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .raw_req({req_r, req_b, req_g}),
        .req_lvl(lvl), .req_fall(fall)
    );

    rgb_code_bank #(.NCH(NUM_CH), .CUR_W(CUR_W), .DLY_W(DLY_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .load(fall),
        .shd_cur({shd_cur_r, shd_cur_b, shd_cur_g}),
        .shd_dly({shd_dly_r, shd_dly_b, shd_dly_g}),
        .app_cur(app_cur), .app_dly(app_dly)
    );

    rgb_arbiter #(.NCH(NUM_CH), .DLY_W(DLY_W), .MIN_US(MIN_US),
                  .STEP_US(STEP_US)) u_arb (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
        .req_lvl(lvl), .app_dly(app_dly),
        .sel_vld(sel_vld), .on_vld(on_vld), .sel_idx(sel_idx)
    );

    // Output decode from the grant state.
    always_comb begin
        ch_en    = '0;
        ch_sel   = '0;
        cur_code = '0;
        if (sel_vld) begin
            ch_sel   = 2'(sel_idx) + 2'd1;
            cur_code = app_cur[sel_idx*CUR_W +: CUR_W];
        end
        if (on_vld) ch_en[sel_idx] = 1'b1;
    end
endmodule

// File: rtl/rgb_seq_checker.sv
// Port-level properties of the sequencer, bound into every instance.
module rgb_seq_checker #(
    parameter int CUR_W   = 10,
    parameter int MIN_US  = 5,
    parameter int STEP_US = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_us,
    input logic [2:0]       ch_en,
    input logic [1:0]       ch_sel,
    input logic [CUR_W-1:0] cur_code
);
    localparam int MAX_US = MIN_US + 3 * STEP_US;
    logic [7:0] blk_ticks;

    // Count ticks seen while a channel is selected but not yet enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || ch_sel == 2'd0) blk_ticks <= '0;
        else if (ch_en == 3'b000 && tick_us && blk_ticks != 8'hFF)
            blk_ticks <= blk_ticks + 8'd1;
    end

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_en));

    p_no_preempt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en != 3'b000) |=> (ch_en == 3'b000) || (ch_en == $past(ch_en)));

    p_blank_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en != 3'b000) |-> ($past(ch_en) != 3'b000) || ($past(ch_sel) == ch_sel));

    p_blank_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_en != 3'b000) && ($past(ch_en) == 3'b000)) |->
        (blk_ticks >= 8'(MIN_US)) && (blk_ticks <= 8'(MAX_US)));

    p_cur_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en != 3'b000) |=> (ch_en != $past(ch_en)) || $stable(cur_code));

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_sel == 2'd0) |-> (ch_en == 3'b000) && (cur_code == '0));
endmodule

bind rgb_seq_top rgb_seq_checker #(.CUR_W(CUR_W), .MIN_US(MIN_US), .STEP_US(STEP_US)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .ch_en(ch_en), .ch_sel(ch_sel), .cur_code(cur_code)
);

// File: tb/rgb_seq_top_test.sv
module rgb_seq_top_test;
    logic clk = 1'b0, rst_n = 1'b0, tick_us = 1'b0;
    logic [2:0] req = 3'b000;            // 0 green, 1 blue, 2 red
    logic [9:0] sh_cur [3];
    logic [1:0] sh_dly [3];
    logic [2:0] ch_en;
    logic [1:0] ch_sel;
    logic [9:0] cur_code;
    int n_chk = 0, n_fail = 0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;

    rgb_seq_top uut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
        .req_g(req[0]), .req_b(req[1]), .req_r(req[2]),
        .shd_cur_g(sh_cur[0]), .shd_cur_b(sh_cur[1]), .shd_cur_r(sh_cur[2]),
        .shd_dly_g(sh_dly[0]), .shd_dly_b(sh_dly[1]), .shd_dly_r(sh_dly[2]),
        .ch_en(ch_en), .ch_sel(ch_sel), .cur_code(cur_code)
    );

    // Reference model built from the requirements.
    logic [2:0] m_s1, m_s2, m_s3;
    logic [9:0] m_cur [3];
    logic [1:0] m_dly [3];
    int m_st, m_idx, m_cnt, m_tgt;   // m_st: 0 idle, 1 blank, 2 on

    function automatic int pick(input logic [2:0] r);
        if (r[0]) return 0;
        if (r[1]) return 1;
        return 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
            m_st <= 0; m_idx <= 0; m_cnt <= 0; m_tgt <= 0;
            for (int i = 0; i < 3; i++) begin m_cur[i] <= 10'h3FF; m_dly[i] <= 2'd3; end
        end else begin
            m_s1 <= req; m_s2 <= m_s1; m_s3 <= m_s2;
            for (int i = 0; i < 3; i++)
                if (m_s3[i] && !m_s2[i]) begin m_cur[i] <= sh_cur[i]; m_dly[i] <= sh_dly[i]; end
            if (m_st == 0) begin
                if (m_s2 != 0) begin
                    m_st <= 1; m_idx <= pick(m_s2); m_cnt <= 0;
                    m_tgt <= 5 + 10 * int'(m_dly[pick(m_s2)]);
                end
            end else if (m_st == 1) begin
                if (!m_s2[m_idx]) m_st <= 0;
                else if (tick_us) begin
                    if (m_cnt + 1 == m_tgt) begin m_st <= 2; m_cnt <= 0; end
                    else m_cnt <= m_cnt + 1;
                end
            end else if (!m_s2[m_idx]) m_st <= 0;
        end
    end

    function automatic logic [2:0] exp_en();
        return (m_st == 2) ? 3'(1 << m_idx) : 3'b000;
    endfunction
    function automatic logic [1:0] exp_sel();
        return (m_st != 0) ? 2'(m_idx + 1) : 2'd0;
    endfunction
    function automatic logic [9:0] exp_cur();
        return (m_st != 0) ? m_cur[m_idx] : 10'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
        end
    endtask

    // Per-cycle comparison against the model (R7 and all state behaviour).
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check("R1 model en", 32'(ch_en), 32'(exp_en()));
            check("R2 model sel", 32'(ch_sel), 32'(exp_sel()));
            check("R7 model cur", 32'(cur_code), 32'(exp_cur()));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 3; i++) begin sh_cur[i] = 10'h3FF; sh_dly[i] = 2'd3; end
        step(3);
        check("R11 reset en", 32'(ch_en), 0);
        check("R11 reset sel", 32'(ch_sel), 0);
        check("R11 reset cur", 32'(cur_code), 0);
        rst_n = 1'b1;
        step(1);
        model_on = 1'b1;
        tick_us = 1'b1;
        check("R11 after reset sel", 32'(ch_sel), 0);

        // Green alone: latency, default delay and current.
        req[0] = 1'b1;
        step(2);  check("R10 sel after 2 edges", 32'(ch_sel), 0);
        step(1);  check("R10 sel after 3 edges", 32'(ch_sel), 1);
        check("R5 default current", 32'(cur_code), 32'h3FF);
        step(34); check("R4 still blank at 34 ticks", 32'(ch_en), 0);
        step(1);  check("R5 on after 35 ticks", 32'(ch_en), 3'b001);

        // Load new green codes at its falling edge.
        sh_cur[0] = 10'h155; sh_dly[0] = 2'd0;
        req[0] = 1'b0;
        step(3);  check("R9 idle after release", 32'(ch_sel), 0);

        // Blue and red together: blue wins; green arrives later and waits.
        req[1] = 1'b1; req[2] = 1'b1;
        step(3);  check("R2 blue over red", 32'(ch_sel), 2);
        step(35); check("R4 blue on", 32'(ch_en), 3'b010);
        req[0] = 1'b1;
        step(50); check("R3 no pre-empt by green", 32'(ch_en), 3'b010);
        req[1] = 1'b0;
        step(3);  check("R9 idle one cycle", 32'(ch_sel), 0);
        step(1);  check("R2 green over red", 32'(ch_sel), 1);
        step(4);  check("R4 green blank 5 ticks", 32'(ch_en), 0);
        step(1);  check("R4 green on after 5", 32'(ch_en), 3'b001);
        check("R6 applied green current", 32'(cur_code), 32'h155);

        // Abort red during blanking.
        req[0] = 1'b0;
        step(4);  check("R2 red selected", 32'(ch_sel), 3);
        req[2] = 1'b0;
        step(3);  check("R8 abort to idle", 32'(ch_sel), 0);
        step(40); check("R8 red never on", 32'(ch_en), 0);

        // Shadow change while blue is low is ignored until its falling edge.
        sh_cur[1] = 10'h0AA;
        step(5);
        req[1] = 1'b1;
        step(3);  check("R6 shadow ignored", 32'(cur_code), 32'h3FF);
        req[1] = 1'b0;
        step(5);
        req[1] = 1'b1;
        step(3);  check("R6 shadow applied at fall", 32'(cur_code), 32'h0AA);
        req[1] = 1'b0;
        step(5);

        // Constrained random phase.
        void'($urandom(32'd1234));
        for (int c = 0; c < 20000; c++) begin
            tick_us = ($urandom % 4) == 0;
            for (int i = 0; i < 3; i++) begin
                if (($urandom % 60) == 0) req[i] = ~req[i];
                if (($urandom % 200) == 0) begin
                    sh_cur[i] = 10'($urandom);
                    sh_dly[i] = 2'($urandom);
                end
            end
            step(1);
        end
        finish_run();
    end
endmodule